// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Front End

This block sits between a host and the inside of a memory device whose 16-bit bus carries both addresses and data. It builds a 22-bit word address from two sources. The shared bus gives the low 16 bits. Six dedicated pins give the upper bits. The address is captured in one of two ways. In asynchronous mode a latch follows the pins while the latch strobe is low and closes when the strobe rises. In synchronous mode the address is taken on the first burst-clock edge of a configured polarity that arrives while the strobe is low.

Write data and commands are taken from the bus on the rising edge of the write strobe. The block also decides when the bus turns around to drive read data. It does so only when chip select and output enable are both low and reset is high. In every other case the bus is released.

All host pins are sampled on an internal system clock. Downstream logic receives the address and write data together with one-cycle valid pulses. Reset clears every captured value.

Top module: `mux_bus_frontend`

## Requirements
- R1: The captured address is `{upperAddr, busIn}`, with the dedicated pins as bits 21..16 and the bus as bits 15..0.
- R2: While `ceN`=0, `oeN`=1 and `leN`=0, and the address is not frozen, `addr` follows the pins. A change at the pins shows on `addr` two system-clock edges later.
- R3: In asynchronous mode (`syncMode`=0), a rising edge on `leN` during the address phase gives exactly one one-cycle `addrValid` pulse. While `leN` stays high, `addr` holds even if the bus changes.
- R4: In synchronous mode (`syncMode`=1), the first selected `busClk` edge seen while `leN` is low captures the address and gives one `addrValid` pulse. After that, `addr` is frozen until `leN` goes high. Later clock edges and bus changes have no effect, and the rise of `leN` gives no pulse.
- R5: `clkRising`=1 selects the rising edge of `busClk`, and `clkRising`=0 selects the falling edge. An edge of the other polarity neither captures nor pulses.
- R6: `busClk` is ignored in asynchronous mode. It is also ignored while `weN` is low: no `addrValid` pulse and no freeze.
- R7: A rising edge on `weN` while `ceN`=0 loads the bus into `wrData` and gives exactly one one-cycle `wrValid` pulse.
- R8: `busOe` is 1 and `busOut` equals `rdData` only when `ceN`=0, `oeN`=0 and `rstN`=1. In every other case `busOe` is 0 and `busOut` is 0.
- R9: While `rstN` is low, `addr` and `wrData` are 0 and `addrValid` and `wrValid` are 0.
- R10: While `ceN` is high, the address does not change and no `addrValid` or `wrValid` pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal system clock that samples all pins |
| rstN | input | 1 | Active-low reset; clears captured values and releases the bus |
| ceN | input | 1 | Active-low chip select |
| oeN | input | 1 | Active-low output enable |
| weN | input | 1 | Active-low write strobe; data is captured on its rising edge |
| leN | input | 1 | Active-low latch strobe for the address |
| busClk | input | 1 | Host burst clock |
| syncMode | input | 1 | 1 selects synchronous address capture |
| clkRising | input | 1 | 1 selects the rising burst-clock edge, 0 the falling edge |
| busIn | input | 16 | Shared bus, input side |
| upperAddr | input | 6 | Dedicated upper address pins |
| rdData | input | 16 | Read data from downstream logic |
| busOut | output | 16 | Shared bus, output side |
| busOe | output | 1 | Drive enable for the shared bus |
| addr | output | 22 | Captured word address |
| addrValid | output | 1 | One-cycle pulse when an address is captured |
| wrData | output | 16 | Captured write data or command |
| wrValid | output | 1 | One-cycle pulse when write data is captured |

## Verification
Some rules hold on every cycle, and the assertions check these continuously:
- the bus is driven only when chip select and output enable are both low and reset is high;
- the bus output is zero while the bus is released;
- both valid strobes last exactly one cycle;
- the address holds while the latch strobe stays high;
- write data changes only together with its valid pulse.

Other behaviour depends on a sequence of events, so only the bench scenarios can show it:
- the one-time freeze after the first selected clock edge;
- the polarity choice of that edge;
- the clock being ignored in asynchronous mode and during writes;
- the absence of a pulse when the latch strobe rises in synchronous mode;
- the exact values captured for random addresses and data.

// File: rtl/mbf_pkg.sv
package mbf_pkg;
  // strobes from control to datapath, all aligned to one system-clock edge
  typedef struct packed {
    logic addrLoad;   // copy sampled pins into the address register
    logic addrMark;   // raise the address-valid pulse
    logic dataLoad;   // copy sampled bus into the write-data register
  } strobe_t;
endpackage

// File: rtl/mbf_ctrl.sv
module mbf_ctrl
  import mbf_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    ceN,
  input  logic    oeN,
  input  logic    weN,
  input  logic    leN,
  input  logic    busClk,
  input  logic    syncMode,
  input  logic    clkRising,
  output strobe_t strb,
  output logic    busOe
);
  // first stage: sampled pins; second stage: previous samples for edge detection
  logic sCe, sOe, sWe, sLe, sK;
  logic pWe, pLe, pK;
  logic frozen;
  logic addrPhase, kEdge, syncHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sCe    <= 1'b1;
      sOe    <= 1'b1;
      sWe    <= 1'b1;
      sLe    <= 1'b1;
      sK     <= 1'b0;
      pWe    <= 1'b1;
      pLe    <= 1'b1;
      pK     <= 1'b0;
      frozen <= 1'b0;
    end else begin
      sCe <= ceN;
      sOe <= oeN;
      sWe <= weN;
      sLe <= leN;
      sK  <= busClk;
      pWe <= sWe;
      pLe <= sLe;
      pK  <= sK;
      if (sLe)          frozen <= 1'b0;
      else if (syncHit) frozen <= 1'b1;
    end
  end

  always_comb begin
    addrPhase = ~sCe & sOe;
    kEdge     = clkRising ? (sK & ~pK) : (~sK & pK);
    syncHit   = syncMode & kEdge & ~sLe & ~frozen & addrPhase & sWe;

    strb.addrLoad = ~sLe & ~frozen & addrPhase;
    strb.addrMark = syncMode ? syncHit : (sLe & ~pLe & addrPhase);
    strb.dataLoad = sWe & ~pWe & ~sCe;

    busOe = rstN & ~ceN & ~oeN;
  end
endmodule

// File: rtl/mbf_datapath.sv
module mbf_datapath
  import mbf_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int HIGH_W = 6,
  localparam int ADDR_W = DATA_W + HIGH_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] busIn,
  input  logic [HIGH_W-1:0] upperAddr,
  input  strobe_t           strb,
  output logic [ADDR_W-1:0] addr,
  output logic              addrValid,
  output logic [DATA_W-1:0] wrData,
  output logic              wrValid
);
  logic [DATA_W-1:0] sBus;
  logic [HIGH_W-1:0] sHigh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sBus      <= '0;
      sHigh     <= '0;
      addr      <= '0;
      addrValid <= 1'b0;
      wrData    <= '0;
      wrValid   <= 1'b0;
    end else begin
      sBus      <= busIn;
      sHigh     <= upperAddr;
      addrValid <= strb.addrMark;
      wrValid   <= strb.dataLoad;
      if (strb.addrLoad) addr   <= {sHigh, sBus};
      if (strb.dataLoad) wrData <= sBus;
    end
  end
endmodule

// File: rtl/mux_bus_frontend.sv
module mux_bus_frontend
  import mbf_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int HIGH_W = 6,
  localparam int ADDR_W = DATA_W + HIGH_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic              leN,
  input  logic              busClk,
  input  logic              syncMode,
  input  logic              clkRising,
  input  logic [DATA_W-1:0] busIn,
  input  logic [HIGH_W-1:0] upperAddr,
  input  logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] busOut,
  output logic              busOe,
  output logic [ADDR_W-1:0] addr,
  output logic              addrValid,
  output logic [DATA_W-1:0] wrData,
  output logic              wrValid
);
  strobe_t strb;

  mbf_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN), .leN(leN),
    .busClk(busClk), .syncMode(syncMode), .clkRising(clkRising),
    .strb(strb), .busOe(busOe)
  );

  mbf_datapath #(.DATA_W(DATA_W), .HIGH_W(HIGH_W)) u_dp (
    .clk(clk), .rstN(rstN), .busIn(busIn), .upperAddr(upperAddr), .strb(strb),
    .addr(addr), .addrValid(addrValid), .wrData(wrData), .wrValid(wrValid)
  );

  assign busOut = busOe ? rdData : '0;
endmodule

// File: rtl/mbf_checker.sv
module mbf_checker #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 22
) (
  input logic              clk,
  input logic              rstN,
  input logic              ceN,
  input logic              oeN,
  input logic              leN,
  input logic [DATA_W-1:0] busOut,
  input logic              busOe,
  input logic [ADDR_W-1:0] addr,
  input logic              addrValid,
  input logic [DATA_W-1:0] wrData,
  input logic              wrValid
);
  a_r8_drive_gate: assert property (@(posedge clk) disable iff (!rstN)
    busOe |-> (!ceN && !oeN));

  a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !busOe |-> (busOut == '0));

  a_r3_addr_pulse_single: assert property (@(posedge clk) disable iff (!rstN)
    addrValid |=> !addrValid);

  a_r7_wr_pulse_single: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |=> !wrValid);

  a_r7_wr_only_with_pulse: assert property (@(posedge clk) disable iff (!rstN)
    !wrValid |-> $stable(wrData));

  a_r3_hold_while_high: assert property (@(posedge clk) disable iff (!rstN)
    (leN && $past(leN)) |=> $stable(addr));
endmodule

bind mux_bus_frontend mbf_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .leN(leN),
  .busOut(busOut), .busOe(busOe), .addr(addr), .addrValid(addrValid),
  .wrData(wrData), .wrValid(wrValid)
);

// File: tb/mux_bus_frontend_bench.sv
module mux_bus_frontend_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0, ceN = 1'b1, oeN = 1'b1, weN = 1'b1, leN = 1'b1;
  logic busClk = 1'b0, syncMode = 1'b0, clkRising = 1'b1;
  logic [15:0] busIn = '0, rdData = '0, busOut, wrData;
  logic [5:0]  upperAddr = '0;
  logic [21:0] addr;
  logic busOe, addrValid, wrValid;

  int checks = 0, fails = 0;
  int aCount = 0, wCount = 0, aSnap, wSnap;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mux_bus_frontend u_mux_bus_frontend (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN), .leN(leN),
    .busClk(busClk), .syncMode(syncMode), .clkRising(clkRising),
    .busIn(busIn), .upperAddr(upperAddr), .rdData(rdData), .busOut(busOut),
    .busOe(busOe), .addr(addr), .addrValid(addrValid), .wrData(wrData),
    .wrValid(wrValid)
  );

  always @(negedge clk) begin
    if (rstN) begin
      aCount += int'(addrValid);
      wCount += int'(wrValid);
    end
  end

  function automatic logic [21:0] expAddr(logic [5:0] hi, logic [15:0] lo);
    return {hi, lo};
  endfunction

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic snap();
    aSnap = aCount;
    wSnap = wCount;
  endtask

  // asynchronous capture: R1, R2, R3
  task automatic asyncAddr(logic [5:0] hi, logic [15:0] lo);
    snap();
    syncMode = 1'b0; ceN = 1'b0; oeN = 1'b1; weN = 1'b1;
    upperAddr = hi; busIn = lo; leN = 1'b0;
    tick(2);
    check("R2 transparent", 32'(addr), 32'(expAddr(hi, lo)));
    leN = 1'b1;
    tick(3);
    check("R3 one pulse on latch rise", 32'(aCount - aSnap), 32'd1);
    busIn = ~lo; upperAddr = ~hi;
    tick(3);
    check("R1 R3 held address", 32'(addr), 32'(expAddr(hi, lo)));
  endtask

  // synchronous capture on the selected edge: R4, R5
  task automatic syncAddr(logic pol, logic [5:0] hi, logic [15:0] lo);
    snap();
    syncMode = 1'b1; clkRising = pol; ceN = 1'b0; oeN = 1'b1; weN = 1'b1;
    busClk = ~pol;
    tick(2);
    upperAddr = hi; busIn = lo; leN = 1'b0;
    tick(2);
    busClk = pol;
    tick(2);
    busIn = ~lo; upperAddr = ~hi;
    tick(1);
    for (int i = 0; i < 4; i++) begin
      busClk = ~busClk;
      tick(2);
    end
    check("R4 frozen capture", 32'(addr), 32'(expAddr(hi, lo)));
    check("R4 single pulse", 32'(aCount - aSnap), 32'd1);
    leN = 1'b1;
    tick(3);
    check("R4 no pulse on latch rise", 32'(aCount - aSnap), 32'd1);
  endtask

  task automatic writeWord(logic [15:0] d);
    snap();
    ceN = 1'b0; oeN = 1'b1; leN = 1'b1; weN = 1'b0; busIn = d;
    tick(2);
    weN = 1'b1;
    tick(3);
    check("R7 write data", 32'(wrData), 32'(d));
    check("R7 one write pulse", 32'(wCount - wSnap), 32'd1);
    busIn = ~d;
    tick(1);
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    tick(2);
    check("R9 reset addr", 32'(addr), 32'd0);
    check("R9 reset wrData", 32'(wrData), 32'd0);
    check("R9 reset pulses", 32'({addrValid, wrValid}), 32'd0);
    check("R8 released in reset", 32'(busOe), 32'd0);
    rstN = 1'b1;
    tick(2);

    // R8: drive gating under all select combinations
    for (int c = 0; c < 4; c++) begin
      logic [15:0] rd;
      rd = 16'($urandom);
      rdData = rd; ceN = c[0]; oeN = c[1];
      #1;
      check("R8 busOe", 32'(busOe), 32'(c == 0));
      check("R8 busOut", 32'(busOut), (c == 0) ? 32'(rd) : 32'd0);
      tick(1);
    end
    ceN = 1'b1; oeN = 1'b1;

    // directed corners
    asyncAddr(6'h3F, 16'hFFFF);
    asyncAddr(6'h00, 16'h0000);
    syncAddr(1'b1, 6'h2A, 16'h1234);
    syncAddr(1'b0, 6'h15, 16'hBEEF);

    // R5: opposite edge is ignored, then selected edge captures
    snap();
    syncMode = 1'b1; clkRising = 1'b1; ceN = 1'b0; oeN = 1'b1; busClk = 1'b1;
    tick(2);
    upperAddr = 6'h01; busIn = 16'hAAAA; leN = 1'b0;
    tick(2);
    busClk = 1'b0;
    tick(3);
    check("R5 wrong edge no pulse", 32'(aCount - aSnap), 32'd0);
    busIn = 16'h5555;
    tick(2);
    check("R5 still transparent", 32'(addr), 32'(expAddr(6'h01, 16'h5555)));
    busClk = 1'b1;
    tick(3);
    check("R5 selected edge pulses", 32'(aCount - aSnap), 32'd1);
    leN = 1'b1;
    tick(2);

    // R6: clock ignored in asynchronous mode
    snap();
    syncMode = 1'b0; leN = 1'b0; busIn = 16'h0F0F;
    for (int i = 0; i < 4; i++) begin
      busClk = ~busClk;
      tick(2);
    end
    check("R6 async clock no pulse", 32'(aCount - aSnap), 32'd0);
    busIn = 16'hF0F0;
    tick(2);
    check("R6 async not frozen", 32'(addr[15:0]), 32'hF0F0);
    leN = 1'b1;
    tick(3);

    // R6: clock ignored while write strobe is low
    snap();
    syncMode = 1'b1; clkRising = 1'b1; busClk = 1'b0; weN = 1'b0; leN = 1'b0;
    tick(2);
    busClk = 1'b1;
    tick(2);
    busClk = 1'b0;
    tick(3);
    check("R6 write clock no pulse", 32'(aCount - aSnap), 32'd0);
    busIn = 16'h7777;
    tick(2);
    check("R6 write not frozen", 32'(addr[15:0]), 32'h7777);
    leN = 1'b1; weN = 1'b1;
    tick(3);

    // R10: deselected chip
    writeWord(16'hC3C3);
    asyncAddr(6'h0C, 16'h00C0);
    snap();
    ceN = 1'b1; leN = 1'b0; busIn = 16'h9999;
    tick(3);
    weN = 1'b0;
    tick(2);
    weN = 1'b1; leN = 1'b1;
    tick(3);
    check("R10 addr untouched", 32'(addr), 32'(expAddr(6'h0C, 16'h00C0)));
    check("R10 no pulses", 32'((aCount - aSnap) + (wCount - wSnap)), 32'd0);
    check("R10 wrData untouched", 32'(wrData), 32'hC3C3);

    // random mix
    for (int it = 0; it < 30; it++) begin
      logic [5:0] hi;
      logic [15:0] lo;
      hi = 6'($urandom);
      lo = 16'($urandom);
      case ($urandom % 3)
        0: asyncAddr(hi, lo);
        1: syncAddr(1'($urandom), hi, lo);
        default: writeWord(lo);
      endcase
    end

    // R9: reset in mid-run
    writeWord(16'hA5A5);
    asyncAddr(6'h11, 16'h2222);
    rstN = 1'b0;
    #1;
    check("R9 mid reset addr", 32'(addr), 32'd0);
    check("R9 mid reset wrData", 32'(wrData), 32'd0);
    ceN = 1'b0; oeN = 1'b0;
    #1;
    check("R9 R8 reset releases bus", 32'(busOe), 32'd0);
    tick(2);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule